// File: doc/BRIEF.md
# Microprocessor Bus Source Selector

This block forms the processor bus word for one microinstruction. From the bus-source code, the register-select field and two flags that say whether either special-function field encodes the constant function, it picks one of several candidate words: the R register, memory data, the S register or a task-specific word. It then merges that word with a constant read from an internal ROM by bitwise AND, which mimics a wired-AND bus. It also reports whether the instruction loads R, and whether it stores M into S at the end of the cycle.

The block also produces the effective register address. For the emulator task, two accumulator-addressing functions replace the low two register-select bits with a field of the instruction register, complemented. The constant ROM is addressed from the unmodified select field. A banked S address is formed from a small bank register held in the block. A host-number mask can further AND the bus with a word whose upper byte is all ones and whose lower byte is the station address.

Top module: `busmux_top`

## Requirements
- R1: With no constant function, code 0 drives `r_data`, code 2 drives all ones (0xFFFF), and codes 6 and 7 drive all ones, so the bus equals the constant entry.
- R2: Code 1 with no constant function gives a bus of 0 and raises `load_r`; in every other case `load_r` is 0.
- R3: Code 5 drives `md_data` ANDed with the constant entry. Every code above 4 ANDs the bus with the constant entry.
- R4: In the emulator task (`emu_task`=1), code 3 drives `s_data` and code 4 gives a bus of 0 and raises `load_s`. In other tasks, codes 3 and 4 drive `task_data` and `load_s` stays 0.
- R5: When `f1_const` or `f2_const` is 1, no source is decoded: the bus equals the constant entry, and `load_r` and `load_s` are 0.
- R6: The constant ROM address `crom_addr` is {`rsel`, `bus_sel`} (select field in bits 7:3). With the default parameter, entry a holds {~a, a}: the complement in the upper byte and the address in the lower byte.
- R7: In the emulator task, `ac_mode`=1 (source accumulator) makes `r_addr` = {`rsel`[4:2], `ir`[14:13] XOR 2'b11}, and `ac_mode`=2 (destination accumulator) makes `r_addr` = {`rsel`[4:2], `ir`[12:11] XOR 2'b11}. Otherwise `r_addr` = `rsel`. The constant ROM address never changes.
- R8: When `host_en` is 1, the bus is further ANDed with {8'hFF, `host_addr`}.
- R9: The S bank is 0 after reset, takes `bank_in` on the clock edge where `bank_we` is 1, and otherwise holds. `s_addr` = {bank, `r_addr`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 3 | Bus-source code |
| rsel | input | 5 | Register-select field |
| f1_const | input | 1 | F1 field encodes the constant function |
| f2_const | input | 1 | F2 field encodes the constant function |
| emu_task | input | 1 | Current task is the emulator |
| ac_mode | input | 2 | 0 none, 1 source accumulator, 2 destination accumulator |
| ir | input | 16 | Instruction register |
| host_en | input | 1 | Apply host-number mask |
| host_addr | input | 8 | Station address for the mask |
| bank_we | input | 1 | Load the S bank register |
| bank_in | input | 3 | New S bank |
| r_data | input | 16 | Selected R word |
| md_data | input | 16 | Memory data word |
| s_data | input | 16 | Selected S word |
| task_data | input | 16 | Task-specific source word |
| bus | output | 16 | Processor bus word |
| load_r | output | 1 | Write R from the shifter at cycle end |
| load_s | output | 1 | Write S from M at cycle end |
| r_addr | output | 5 | Effective register address |
| s_addr | output | 8 | Banked S address |
| crom_addr | output | 8 | Constant ROM address |

## Verification
The hardest case to reach is the stacking of all three AND terms: a code above 4, the host mask, and accumulator substitution active at once. In that case the constant must follow the raw select field, while `r_addr` follows the instruction register. The stimulus sets `ir` so that the substituted bits differ from `rsel`'s low bits, then checks the bus and the two addresses in the same cycle. The bank register is first loaded to a non-zero bank, so that `s_addr` also shows the substituted address under a live bank.

// File: rtl/busmux_pkg.sv
package busmux_pkg;
    localparam int BUS_W  = 16;
    localparam int SEL_W  = 3;
    localparam int RSEL_W = 5;
    localparam int BANK_W = 3;
    localparam int CROM_AW = RSEL_W + SEL_W;

    typedef enum logic [SEL_W-1:0] {
        SRC_RREG  = 3'd0,
        SRC_LOADR = 3'd1,
        SRC_NONE  = 3'd2,
        SRC_TASKA = 3'd3,
        SRC_TASKB = 3'd4,
        SRC_MEMD  = 3'd5,
        SRC_EXT6  = 3'd6,
        SRC_EXT7  = 3'd7
    } bus_src_e;

    typedef enum logic [1:0] {
        AC_NONE = 2'd0,
        AC_SRC  = 2'd1,
        AC_DST  = 2'd2,
        AC_RSVD = 2'd3
    } ac_mode_e;

    function automatic logic [BUS_W-1:0] crom_entry(input logic [CROM_AW-1:0] a,
                                                    input logic [BUS_W-1:0] xr);
        return {~a, a} ^ xr;
    endfunction
endpackage

// File: rtl/busmux_crom.sv
module busmux_crom
    import busmux_pkg::*;
#(
    parameter logic [BUS_W-1:0] CROM_XOR = '0
) (
    input  logic [CROM_AW-1:0] addr,
    output logic [BUS_W-1:0]   word
);
    always_comb begin
        word = crom_entry(addr, CROM_XOR);
    end
endmodule

// File: rtl/busmux_regsel.sv
module busmux_regsel
    import busmux_pkg::*;
(
    input  logic [RSEL_W-1:0] rsel,
    input  logic              emu_task,
    input  logic [1:0]        ac_mode,
    input  logic [BUS_W-1:0]  ir,
    output logic [RSEL_W-1:0] r_addr
);
    logic [1:0] src_ac;
    logic [1:0] dst_ac;

    always_comb begin
        src_ac = ir[BUS_W-2:BUS_W-3] ^ 2'b11;
        dst_ac = ir[BUS_W-4:BUS_W-5] ^ 2'b11;
        r_addr = rsel;
        if (emu_task) begin
            unique case (ac_mode_e'(ac_mode))
                AC_SRC:  r_addr = {rsel[RSEL_W-1:2], src_ac};
                AC_DST:  r_addr = {rsel[RSEL_W-1:2], dst_ac};
                default: r_addr = rsel;
            endcase
        end
    end
endmodule

// File: rtl/busmux_bank.sv
module busmux_bank
    import busmux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_we,
    input  logic [BANK_W-1:0] bank_in,
    output logic [BANK_W-1:0] bank_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bank_q <= '0;
        else if (bank_we) bank_q <= bank_in;
    end
endmodule

// File: rtl/busmux_top.sv
module busmux_top
    import busmux_pkg::*;
#(
    parameter logic [BUS_W-1:0] CROM_XOR = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    bus_sel,
    input  logic [RSEL_W-1:0]   rsel,
    input  logic                f1_const,
    input  logic                f2_const,
    input  logic                emu_task,
    input  logic [1:0]          ac_mode,
    input  logic [BUS_W-1:0]    ir,
    input  logic                host_en,
    input  logic [7:0]          host_addr,
    input  logic                bank_we,
    input  logic [BANK_W-1:0]   bank_in,
    input  logic [BUS_W-1:0]    r_data,
    input  logic [BUS_W-1:0]    md_data,
    input  logic [BUS_W-1:0]    s_data,
    input  logic [BUS_W-1:0]    task_data,
    output logic [BUS_W-1:0]    bus,
    output logic                load_r,
    output logic                load_s,
    output logic [RSEL_W-1:0]   r_addr,
    output logic [BANK_W+RSEL_W-1:0] s_addr,
    output logic [CROM_AW-1:0]  crom_addr
);
    logic [BUS_W-1:0]  const_word;
    logic [BUS_W-1:0]  src_word;
    logic [BUS_W-1:0]  host_mask;
    logic [BANK_W-1:0] bank_q;
    logic              const_fn;
    logic              gate_const;

    assign crom_addr = {rsel, bus_sel};

    busmux_crom #(.CROM_XOR(CROM_XOR)) u_crom (
        .addr (crom_addr),
        .word (const_word)
    );

    busmux_regsel u_regsel (
        .rsel     (rsel),
        .emu_task (emu_task),
        .ac_mode  (ac_mode),
        .ir       (ir),
        .r_addr   (r_addr)
    );

    busmux_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank_we (bank_we),
        .bank_in (bank_in),
        .bank_q  (bank_q)
    );

    assign s_addr = {bank_q, r_addr};

    // Source decode: undriven bus lines float high, so "no source" is all ones.
    always_comb begin
        const_fn = f1_const | f2_const;
        src_word = '1;
        load_r   = 1'b0;
        load_s   = 1'b0;
        if (!const_fn) begin
            unique case (bus_src_e'(bus_sel))
                SRC_RREG:  src_word = r_data;
                SRC_LOADR: begin
                    src_word = '0;
                    load_r   = 1'b1;
                end
                SRC_NONE:  src_word = '1;
                SRC_TASKA: src_word = emu_task ? s_data : task_data;
                SRC_TASKB: begin
                    src_word = emu_task ? '0 : task_data;
                    load_s   = emu_task;
                end
                SRC_MEMD:  src_word = md_data;
                SRC_EXT6,
                SRC_EXT7:  src_word = '1;
            endcase
        end
    end

    // Wired-AND merge of source, constant and host mask.
    always_comb begin
        gate_const = const_fn | (bus_sel > SEL_W'(4));
        host_mask  = host_en ? {8'hFF, host_addr} : '1;
        bus        = src_word & (gate_const ? const_word : '1) & host_mask;
    end
endmodule

// File: rtl/busmux_chk.sv
module busmux_chk
    import busmux_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic [SEL_W-1:0]           bus_sel,
    input logic [RSEL_W-1:0]          rsel,
    input logic                       f1_const,
    input logic                       f2_const,
    input logic                       emu_task,
    input logic [1:0]                 ac_mode,
    input logic                       host_en,
    input logic                       bank_we,
    input logic [BANK_W-1:0]          bank_in,
    input logic [BUS_W-1:0]           bus,
    input logic                       load_r,
    input logic                       load_s,
    input logic [RSEL_W-1:0]          r_addr,
    input logic [BANK_W+RSEL_W-1:0]   s_addr
);
    // R2
    assert_loadr_zero_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_r |-> (bus == '0 && bus_sel == 3'd1 && !f1_const && !f2_const));

    // R1
    assert_none_all_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 3'd2 && !f1_const && !f2_const && !host_en) |-> bus == 16'hFFFF);

    // R5
    assert_const_no_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (f1_const || f2_const) |-> (!load_r && !load_s));

    // R4
    assert_loads_emu_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_s |-> (emu_task && bus_sel == 3'd4));

    // R7
    assert_plain_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!emu_task || ac_mode == 2'd0) |-> r_addr == rsel);

    // R9
    assert_bank_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> s_addr[BANK_W+RSEL_W-1:RSEL_W] == $past(bank_in));

    assert_bank_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we |=> $stable(s_addr[BANK_W+RSEL_W-1:RSEL_W]));
endmodule

bind busmux_top busmux_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .rsel     (rsel),
    .f1_const (f1_const),
    .f2_const (f2_const),
    .emu_task (emu_task),
    .ac_mode  (ac_mode),
    .host_en  (host_en),
    .bank_we  (bank_we),
    .bank_in  (bank_in),
    .bus      (bus),
    .load_r   (load_r),
    .load_s   (load_s),
    .r_addr   (r_addr),
    .s_addr   (s_addr)
);

// File: tb/sim_busmux_top.sv
module sim_busmux_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_sel = '0;
    logic [4:0]  rsel = '0;
    logic        f1_const = 1'b0;
    logic        f2_const = 1'b0;
    logic        emu_task = 1'b0;
    logic [1:0]  ac_mode = '0;
    logic [15:0] ir = '0;
    logic        host_en = 1'b0;
    logic [7:0]  host_addr = '0;
    logic        bank_we = 1'b0;
    logic [2:0]  bank_in = '0;
    logic [15:0] r_data = 16'h1234;
    logic [15:0] md_data = 16'hBEEF;
    logic [15:0] s_data = 16'h5A5A;
    logic [15:0] task_data = 16'hC3C3;
    logic [15:0] bus;
    logic        load_r, load_s;
    logic [4:0]  r_addr;
    logic [7:0]  s_addr;
    logic [7:0]  crom_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busmux_top u0 (.*);

    function automatic logic [15:0] rom_of(input logic [4:0] rs, input logic [2:0] sl);
        logic [7:0] a;
        a = {rs, sl};
        return {~a, a};
    endfunction

    function automatic logic [15:0] exp_bus();
        logic [15:0] b;
        if (f1_const || f2_const) b = rom_of(rsel, bus_sel);
        else begin
            case (bus_sel)
                3'd0: b = r_data;
                3'd1: b = 16'h0000;
                3'd3: b = emu_task ? s_data : task_data;
                3'd4: b = emu_task ? 16'h0000 : task_data;
                3'd5: b = md_data;
                default: b = 16'hFFFF;
            endcase
            if (bus_sel > 3'd4) b = b & rom_of(rsel, bus_sel);
        end
        if (host_en) b = b & {8'hFF, host_addr};
        return b;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic apply(input logic [2:0] sl, input logic [4:0] rs);
        @(negedge clk);
        bus_sel = sl;
        rsel    = rs;
        #1;
    endtask

    task automatic t_reset();
        chk("R9 reset bank", 32'(s_addr[7:5]), 32'd0);
        chk("R2 reset load_r", 32'(load_r), 32'd0);
    endtask

    task automatic t_plain_sources();
        emu_task = 1'b0;
        apply(3'd0, 5'd7);  chk("R1 rreg", 32'(bus), 32'(exp_bus()));
        apply(3'd2, 5'd7);  chk("R1 none", 32'(bus), 32'hFFFF);
        apply(3'd6, 5'd9);  chk("R1 code6", 32'(bus), 32'(rom_of(5'd9, 3'd6)));
        apply(3'd7, 5'd30); chk("R1 code7", 32'(bus), 32'(rom_of(5'd30, 3'd7)));
        apply(3'd1, 5'd4);
        chk("R2 bus0", 32'(bus), 32'd0);
        chk("R2 load_r", 32'(load_r), 32'd1);
        apply(3'd0, 5'd4);  chk("R2 load_r low", 32'(load_r), 32'd0);
    endtask

    task automatic t_memory();
        apply(3'd5, 5'd17);
        chk("R3 md&const", 32'(bus), 32'(md_data & rom_of(5'd17, 3'd5)));
        md_data = 16'hFFFF;
        apply(3'd5, 5'd3);
        chk("R3 const only", 32'(bus), 32'(rom_of(5'd3, 3'd5)));
        md_data = 16'hBEEF;
    endtask

    task automatic t_task_codes();
        emu_task = 1'b1;
        apply(3'd3, 5'd2);
        chk("R4 emu read S", 32'(bus), 32'(s_data));
        apply(3'd4, 5'd2);
        chk("R4 emu store bus", 32'(bus), 32'd0);
        chk("R4 emu load_s", 32'(load_s), 32'd1);
        emu_task = 1'b0;
        apply(3'd3, 5'd2);
        chk("R4 task3", 32'(bus), 32'(task_data));
        apply(3'd4, 5'd2);
        chk("R4 task4", 32'(bus), 32'(task_data));
        chk("R4 no load_s", 32'(load_s), 32'd0);
    endtask

    task automatic t_const_fn();
        emu_task = 1'b1;
        f1_const = 1'b1;
        apply(3'd1, 5'd21);
        chk("R5 f1 bus", 32'(bus), 32'(rom_of(5'd21, 3'd1)));
        chk("R5 f1 no load_r", 32'(load_r), 32'd0);
        f1_const = 1'b0; f2_const = 1'b1;
        apply(3'd4, 5'd11);
        chk("R5 f2 bus", 32'(bus), 32'(rom_of(5'd11, 3'd4)));
        chk("R5 f2 no load_s", 32'(load_s), 32'd0);
        f2_const = 1'b0;
        emu_task = 1'b0;
    endtask

    task automatic t_rom_addr();
        apply(3'd6, 5'b10110);
        chk("R6 crom_addr", 32'(crom_addr), 32'h00B6);
        chk("R6 entry", 32'(bus), 32'h49B6);
    endtask

    task automatic t_accum();
        emu_task = 1'b1;
        ir = 16'b0_10_01_00000000000;
        ac_mode = 2'd1;
        apply(3'd0, 5'b11100);
        chk("R7 src acc", 32'(r_addr), 32'(5'b11101));
        ac_mode = 2'd2;
        #1;
        chk("R7 dst acc", 32'(r_addr), 32'(5'b11110));
        chk("R7 rom addr kept", 32'(crom_addr), 32'({5'b11100, 3'd0}));
        emu_task = 1'b0;
        #1;
        chk("R7 non-emu", 32'(r_addr), 32'(5'b11100));
        ac_mode = 2'd0;
    endtask

    task automatic t_host_and_bank();
        @(negedge clk);
        bank_we = 1'b1; bank_in = 3'd5;
        @(negedge clk);
        bank_we = 1'b0; bank_in = 3'd2;
        chk("R9 bank load", 32'(s_addr[7:5]), 32'd5);
        @(negedge clk);
        chk("R9 bank hold", 32'(s_addr[7:5]), 32'd5);
        emu_task = 1'b1; ac_mode = 2'd1; ir = 16'h0000;
        host_en = 1'b1; host_addr = 8'h42;
        apply(3'd7, 5'b01000);
        chk("R8 host+const", 32'(bus), 32'(rom_of(5'b01000, 3'd7) & 16'hFF42));
        chk("R9 s_addr", 32'(s_addr), 32'({3'd5, 5'b01011}));
        apply(3'd2, 5'd0);
        chk("R8 host mask", 32'(bus), 32'hFF42);
        host_en = 1'b0; emu_task = 1'b0; ac_mode = 2'd0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_plain_sources();
        t_memory();
        t_task_codes();
        t_const_fn();
        t_rom_addr();
        t_accum();
        t_host_and_bank();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule